// File: doc/BRIEF.md
# Loop-Aware Domain Assignment Sequencer

This block hands out a domain index to each instruction of a stream that arrives in profiled execution order. Each domain holds a fixed number of instructions. The block counts how full the current domain is and moves to the next domain when the current one is full.

Some instructions are tagged as the first instruction of a loop, and such an instruction carries the loop's static size. For these, the block checks whether the whole loop still fits in the space left in the current domain. A loop that does not fit there, but would fit in an empty domain, makes the block close the current domain early. The loop then starts in a fresh domain and is not split across two domains. A loop larger than a whole domain cannot avoid a split, so it just continues in the current domain.

The upstream producer sets the loop flag only on the first instruction of each loop. Instructions are accepted through a valid/ready handshake, one per cycle. Each result is a domain index plus a pulse that marks the first instruction placed in a new domain. The result is held in a registered output stage until the consumer takes it.

Top module: `loop_domain_sequencer`

## Requirements
- R1: After reset the output is not valid. The first instruction accepted is given domain 0 with the advance flag low.
- R2: A plain instruction (loop flag low) accepted while the current domain holds fewer than CAPACITY instructions is given the current domain, with the advance flag low.
- R3: An instruction accepted while the current domain already holds CAPACITY instructions is given the next domain index, with the advance flag high. The new domain then holds that one instruction.
- R4: A loop-start instruction whose loop size is less than or equal to the free space (CAPACITY minus the fill count) stays in the current domain with the advance flag low. This includes a loop of size exactly CAPACITY that starts in an empty domain.
- R5: A loop-start instruction whose loop size is greater than the free space and no greater than CAPACITY closes the current domain. It is given the next domain index with the advance flag high, and the fill count restarts at one.
- R6: A loop-start instruction whose loop size is greater than CAPACITY stays in the current domain, unless that domain is full, in which case R3 applies.
- R7: in_ready is high exactly when the output register is empty or out_ready is high. While out_valid is high and out_ready is low, out_domain and out_advance hold their values and no new input is accepted.
- R8: Cycles with in_valid low change neither the domain index nor the fill count. The next accepted instruction is placed as if those idle cycles had not occurred.
- R9: Each accepted instruction appears on the output one cycle after acceptance. Domain indices advance by exactly one at each advance pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when in_valid is high |
| in_loop_start | input | 1 | Instruction is the first of a loop |
| in_loop_size | input | SIZE_W | Static size of the loop (used only with in_loop_start) |
| out_valid | output | 1 | Assignment result held |
| out_ready | input | 1 | Consumer takes the result |
| out_domain | output | DOM_W | Domain index given to the instruction |
| out_advance | output | 1 | High on the first instruction of a new domain |

## Verification
The assertions take for granted that the producer raises the loop flag only on a loop's first instruction. They also assume that any loop size offered fits in SIZE_W. Under these assumptions the advance decisions follow from the fill count alone. The directed stimulus drives the flag with a single instruction per loop and uses loop sizes chosen around the free space and around CAPACITY, with margin to the width limits. The output-hold checks are exercised only by stalls that the bench raises on purpose through out_ready.

// File: rtl/ldas_pkg.sv
// Package: shared decision record for the loop-aware domain sequencer.
// Assumes: nothing beyond being compiled first.
package ldas_pkg;

    // Why an instruction opens a new domain (at most one reason applies).
    typedef struct packed {
        logic advance;   // instruction goes to the next domain
        logic by_loop;   // early close caused by a loop that would split
        logic by_full;   // current domain already at capacity
    } ldas_decision_t;

endpackage

// File: rtl/ldas_fit_check.sv
// Module: ldas_fit_check
// Decides, for the instruction being offered, whether it opens a new domain.
// The decision comes from the current fill count, the loop-start flag and the
// loop size. Assumes the loop flag is raised only on a loop's first instruction.
module ldas_fit_check
    import ldas_pkg::*;
#(
    parameter int CAPACITY = 512,
    parameter int SIZE_W   = 16,
    parameter int FILL_W   = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    input  logic              loop_start,
    input  logic [SIZE_W-1:0] loop_size,
    output ldas_decision_t    decision
);
    localparam int CMP_W = ((SIZE_W > FILL_W) ? SIZE_W : FILL_W) + 1;
    localparam logic [CMP_W-1:0] CAP_X = CMP_W'(CAPACITY);

    logic [CMP_W-1:0] size_x;
    logic [CMP_W-1:0] room_x;
    logic             full;
    logic             split_avoid;

    // Purpose: widen operands so the size/room comparisons cannot overflow.
    always_comb begin
        size_x = CMP_W'(loop_size);
        room_x = CAP_X - CMP_W'(fill);
    end

    // Purpose: apply the capacity rule and the early-close rule for loops.
    always_comb begin
        full        = (CMP_W'(fill) == CAP_X);
        split_avoid = loop_start && !full && (size_x > room_x) && (size_x <= CAP_X);
        decision.by_full = full;
        decision.by_loop = split_avoid;
        decision.advance = full || split_avoid;
    end

    // R5: an early close needs a loop start and a partly filled domain
    assert_loop_close_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        decision.by_loop |-> (loop_start && (fill != '0)));

    // R6: loops bigger than a domain never force an early close
    assert_oversize_no_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start && (size_x > CAP_X) && (CMP_W'(fill) != CAP_X)) |-> !decision.advance);

endmodule

// File: rtl/ldas_fill_tracker.sv
// Module: ldas_fill_tracker
// Holds the current domain index and its fill count. Each accepted instruction
// either adds one to the fill count or opens the next domain, where it counts
// as the first instruction. Assumes accept is already qualified by the handshake.
module ldas_fill_tracker #(
    parameter int CAPACITY = 512,
    parameter int DOM_W    = 8,
    parameter int FILL_W   = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              advance,
    output logic [FILL_W-1:0] fill,
    output logic [DOM_W-1:0]  domain,
    output logic [DOM_W-1:0]  next_domain
);
    localparam logic [FILL_W-1:0] ONE = FILL_W'(1);

    // Purpose: domain index that the offered instruction would receive.
    always_comb begin
        next_domain = advance ? domain + DOM_W'(1) : domain;
    end

    // Purpose: update fill count and domain index on every accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill   <= '0;
            domain <= '0;
        end else if (accept) begin
            domain <= next_domain;
            fill   <= advance ? ONE : fill + ONE;
        end
    end

    // R3: the fill count never goes beyond one domain's capacity
    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(CAPACITY));

    // R9: an advance moves the index by exactly one and restarts the count
    assert_advance_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && advance) |=> (domain == $past(domain) + DOM_W'(1)) && (fill == ONE));

    // R2: a non-advancing instruction keeps the domain and adds one
    assert_same_domain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !advance) |=> (domain == $past(domain)) && (fill == $past(fill) + ONE));

    // R8: no acceptance, no change
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(domain) && $stable(fill));

endmodule

// File: rtl/ldas_out_stage.sv
// Module: ldas_out_stage
// One-entry output register with a valid/ready handshake. It is loaded when
// the entry is empty or being drained in the same cycle.
// Assumes the consumer may hold out_ready low for any number of cycles.
module ldas_out_stage #(
    parameter int DOM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DOM_W-1:0] in_domain,
    input  logic             in_advance,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DOM_W-1:0] out_domain,
    output logic             out_advance
);
    // Purpose: accept a new entry when the register is free or draining.
    always_comb begin
        in_ready = !out_valid || out_ready;
    end

    // Purpose: load, hold or empty the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_domain  <= '0;
            out_advance <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_domain  <= in_domain;
                out_advance <= in_advance;
            end
        end
    end

    // R7: a stalled result stays put
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_domain) && $stable(out_advance));

    // R9: an accepted instruction is presented on the next cycle
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/loop_domain_sequencer.sv
// Module: loop_domain_sequencer (top)
// Assigns a domain index to each instruction of a profiled-order stream and
// closes a domain early so that a loop which fits in an empty domain is never
// split. Assumes the loop flag marks only the first instruction of each loop.
module loop_domain_sequencer
    import ldas_pkg::*;
#(
    parameter int CAPACITY = 512,
    parameter int SIZE_W   = 16,
    parameter int DOM_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_loop_start,
    input  logic [SIZE_W-1:0] in_loop_size,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DOM_W-1:0]  out_domain,
    output logic              out_advance
);
    localparam int FILL_W = $clog2(CAPACITY + 1);

    ldas_decision_t    decision;
    logic [FILL_W-1:0] fill;
    logic [DOM_W-1:0]  domain;
    logic [DOM_W-1:0]  next_domain;
    logic              accept;

    // Purpose: an instruction is taken when offered and the output can accept.
    always_comb begin
        accept = in_valid && in_ready;
    end

    ldas_fit_check #(
        .CAPACITY (CAPACITY),
        .SIZE_W   (SIZE_W),
        .FILL_W   (FILL_W)
    ) u_fit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill       (fill),
        .loop_start (in_loop_start),
        .loop_size  (in_loop_size),
        .decision   (decision)
    );

    ldas_fill_tracker #(
        .CAPACITY (CAPACITY),
        .DOM_W    (DOM_W),
        .FILL_W   (FILL_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .advance     (decision.advance),
        .fill        (fill),
        .domain      (domain),
        .next_domain (next_domain)
    );

    ldas_out_stage #(
        .DOM_W (DOM_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_domain   (next_domain),
        .in_advance  (decision.advance),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_domain  (out_domain),
        .out_advance (out_advance)
    );

    // R7: the ready signal follows the state of the output register
    assert_ready_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1: the first result after reset is the first domain
    assert_first_domain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0 && accept) |=> (out_domain == '0) && !out_advance);

endmodule

// File: tb/loop_domain_sequencer_test.sv
`timescale 1ns/1ps
module loop_domain_sequencer_test;
    localparam int CAP    = 512;
    localparam int SIZE_W = 16;
    localparam int DOM_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_loop_start = 1'b0;
    logic [SIZE_W-1:0] in_loop_size = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DOM_W-1:0]  out_domain;
    logic              out_advance;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    loop_domain_sequencer #(.CAPACITY(CAP), .SIZE_W(SIZE_W), .DOM_W(DOM_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_loop_start(in_loop_start), .in_loop_size(in_loop_size),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_domain(out_domain), .out_advance(out_advance));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one instruction (out_ready high), check the result one cycle later.
    task automatic send(input bit lp, input int size, input int exp_dom,
                        input bit exp_adv, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_loop_start = lp; in_loop_size = SIZE_W'(size);
        @(negedge clk);
        in_valid = 1'b0; in_loop_start = 1'b0;
        check(out_valid === 1'b1, req, int'(out_valid), 1);
        check(out_domain === DOM_W'(exp_dom), req, int'(out_domain), exp_dom);
        check(out_advance === exp_adv, req, int'(out_advance), int'(exp_adv));
    endtask

    task automatic test_reset_and_fill();
        do_reset();
        @(negedge clk);
        check(out_valid === 1'b0, "R1", int'(out_valid), 0);
        send(0, 0, 0, 0, "R1");
        for (int i = 1; i < CAP; i++) send(0, 0, 0, 0, "R2");
        send(0, 0, 1, 1, "R3");          // domain 0 full
        send(0, 0, 1, 0, "R3");          // new domain counted the trigger
    endtask

    task automatic test_loops();
        do_reset();
        send(1, CAP, 0, 0, "R4");        // exact fit in empty domain
        do_reset();
        send(0, 0, 0, 0, "R2");          // fill 1, room 511
        send(1, 511, 0, 0, "R4");        // equal to room: stays
        do_reset();
        send(0, 0, 0, 0, "R2");
        send(0, 0, 0, 0, "R2");          // fill 2, room 510
        send(1, 511, 1, 1, "R5");        // would split: close
        send(1, 600, 1, 0, "R6");        // too big for any domain
        send(1, CAP, 2, 1, "R5");        // fill 2 -> close for full-size loop
        send(1, 100, 2, 0, "R4");
    endtask

    task automatic test_stall();
        do_reset();
        out_ready = 1'b0;
        send(0, 0, 0, 0, "R7");          // taken into empty register
        @(negedge clk);
        check(in_ready === 1'b0, "R7", int'(in_ready), 0);
        in_valid = 1'b1; in_loop_start = 1'b1; in_loop_size = SIZE_W'(CAP);
        repeat (3) @(negedge clk);
        check(out_domain === 8'd0 && out_advance === 1'b0 && out_valid === 1'b1,
              "R7", int'(out_domain), 0);
        in_valid = 1'b0; in_loop_start = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R7", int'(out_valid), 0);
        // stalled offer must not have been counted: fill 1, room 511
        send(1, 511, 0, 0, "R7");
    endtask

    task automatic test_idle();
        do_reset();
        send(0, 0, 0, 0, "R8");
        in_loop_start = 1'b1; in_loop_size = SIZE_W'(CAP);
        repeat (5) @(negedge clk);      // in_valid low with loop inputs set
        in_loop_start = 1'b0;
        check(out_valid === 1'b0, "R9", int'(out_valid), 0);
        send(1, 511, 0, 0, "R8");       // still fill 1
        send(1, 511, 1, 1, "R8");       // fill 2 now closes
    endtask

    initial begin
        test_reset_and_fill();
        test_loops();
        test_stall();
        test_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule